// File: doc/BRIEF.md
# Two-Section Decade Counter with Selectable Cascade Order

This block counts to ten using two small counters kept apart: a single-bit toggle stage and a modulo-five stage. Each stage has its own count strobe. A cascade-order setting decides which stage feeds the other inside the block. In BCD order the toggle stage feeds the modulo-five stage, and the four outputs read as an 8421 digit. In symmetric order the modulo-five stage feeds the toggle stage, and the toggle bit gives a square wave at one tenth of the input rate.

All logic runs on one system clock. The strobes are never used as clocks. Each strobe is registered, and a stage steps in the clock cycle where its strobe is seen to have dropped from high to low. When one stage feeds the other inside the block, the second stage steps in the same cycle as the first.

Two override controls stop counting. Each is a pair of active-high inputs, and each acts only when both inputs of its pair are high. One pair forces the count to zero. The other pair forces nine. The block also gives a one-cycle carry when the decade wraps to zero, and a flag that is high only when the outputs form a valid BCD digit.

Top module: `bisection_decade`

## Requirements
- R1: A low `rst_n` at a clock edge clears all four count bits and `decade_carry`, and selects BCD order, so `bcd_ok` reads 1.
- R2: A stage steps only at the first clock edge where its strobe is sampled low after being sampled high at the edge before. A strobe held high, or one that is rising, does not change the count.
- R3: In BCD order, after n falling edges on `strobe_two` counted from zero, {q_d,q_c,q_b,q_a} equals n mod 10 in 8421 code, with q_a as the least significant bit.
- R4: In BCD order, falling edges on `strobe_five` leave all four count bits unchanged.
- R5: In symmetric order, each falling edge on `strobe_five` steps {q_d,q_c,q_b} through the binary values 0,1,2,3,4 and then back to 0. q_a toggles only on the step from 3 to 4. Starting from zero, q_a is high after steps 4 to 8 of each ten.
- R6: In symmetric order, falling edges on `strobe_two` leave all four count bits unchanged.
- R7: `bcd_ok` is 1 in BCD order and 0 in symmetric order.
- R8: While `zero_a` and `zero_b` are both high and the set-to-nine pair is not both high, the count is held at 0 and strobes have no effect. Either input of the pair alone has no effect.
- R9: While `nine_a` and `nine_b` are both high, the count is held at nine (q_a=1, q_b=0, q_c=0, q_d=1). This holds even when the zero pair is also both high. Either input of the pair alone has no effect.
- R10: `decade_carry` is high for exactly one cycle, at the same edge where a counting step brings the count from its last state to all zeros. In BCD order that last state is 9. In symmetric order it is q_d=1, q_a=0. An override never raises the carry.
- R11: `order_sym` (0 = BCD, 1 = symmetric) is taken only at edges where both zero inputs are high. At any other time, changing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| strobe_two | input | 1 | Count strobe of the toggle stage |
| strobe_five | input | 1 | Count strobe of the modulo-five stage |
| order_sym | input | 1 | Cascade order, taken while clearing (0 BCD, 1 symmetric) |
| zero_a | input | 1 | Reset-to-zero pair, first input |
| zero_b | input | 1 | Reset-to-zero pair, second input |
| nine_a | input | 1 | Set-to-nine pair, first input |
| nine_b | input | 1 | Set-to-nine pair, second input |
| q_a | output | 1 | Toggle stage bit |
| q_b | output | 1 | Modulo-five stage bit 0 |
| q_c | output | 1 | Modulo-five stage bit 1 |
| q_d | output | 1 | Modulo-five stage bit 2 |
| decade_carry | output | 1 | One-cycle pulse on decade wrap |
| bcd_ok | output | 1 | High when the outputs form a BCD digit |

## Verification
The counting function is driven four ways.

- Strobe pulses on the toggle input in BCD order, run through a wrap. This separates a correct 8421 sequence, and a carry at the 9-to-0 step, from a stage that wraps at the wrong count.
- Pulses on the modulo-five input in symmetric order, over two full decades. This shows whether the toggle bit moves only when the middle bit drops, and whether it stays high for five of every ten steps.
- Pulses on the strobe that the current order ignores, and a strobe held high for several cycles. These tell edge counting apart from level counting, and show which strobe each order listens to.
- Each override pair driven one input at a time and then in full, including both pairs at once, and a change of cascade order outside a clear. These confirm the pair gating, the priority of set-to-nine, and when the order setting is taken.

// File: rtl/dec_pkg.sv
// Shared types and constants for the two-section decade counter.
package dec_pkg;

    // Cascade order; the encoding matches the order_sym input.
    typedef enum logic {
        ORDER_BCD = 1'b0,
        ORDER_SYM = 1'b1
    } order_e;

    localparam int FIVE_MOD = 5;
    localparam int FIVE_W   = $clog2(FIVE_MOD);

endpackage

// File: rtl/fall_detect.sv
// Falling-edge detector for W strobe lines, sampled on the system clock.
// Assumes the strobes are synchronous to clk. Each fall bit is high in the
// cycle where the line is low and its registered copy is high.
module fall_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_q;

    // Register the previous level of every strobe line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    // A falling edge is a registered high with a present low.
    for (genvar i = 0; i < W; i++) begin : g_edge
        assign fall[i] = prev_q[i] & ~din[i];
    end

endmodule

// File: rtl/half_stage.sv
// Toggle stage: a one-bit counter that divides by two.
// Assumes load_one has priority over load_zero, and that both loads
// have priority over step.
module half_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic load_zero,
    input  logic load_one,
    input  logic step,
    output logic q
);

    // Update the bit: load first, otherwise toggle on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= 1'b0;
        else if (load_one)  q <= 1'b1;
        else if (load_zero) q <= 1'b0;
        else if (step)      q <= ~q;
    end

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_zero && !load_one) |=> $stable(q)); // R2

endmodule

// File: rtl/quint_stage.sv
// Modulo-MOD stage: a binary counter running 0..MOD-1 that wraps to 0.
// Assumes load_top has priority over load_zero, and that both loads
// have priority over step.
module quint_stage #(
    parameter int MOD = 5,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_zero,
    input  logic         load_top,
    input  logic         step,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = W'(MOD - 1);

    // Load, or step with a wrap at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load_top)  cnt <= TOP;
        else if (load_zero) cnt <= '0;
        else if (step)      cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
    end

    AST_FIVE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP); // R5
    AST_FIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_zero && !load_top) |=> $stable(cnt)); // R2

endmodule

// File: rtl/bisection_decade.sv
// Decade counter built from a toggle stage and a modulo-five stage.
// The cascade order is chosen while clearing. Assumes all inputs are
// synchronous to clk. Override pairs act only with both inputs high,
// and set-to-nine wins over reset-to-zero.
module bisection_decade
    import dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_two,
    input  logic strobe_five,
    input  logic order_sym,
    input  logic zero_a,
    input  logic zero_b,
    input  logic nine_a,
    input  logic nine_b,
    output logic q_a,
    output logic q_b,
    output logic q_c,
    output logic q_d,
    output logic decade_carry,
    output logic bcd_ok
);

    localparam logic [FIVE_W-1:0] FIVE_TOP = FIVE_W'(FIVE_MOD - 1);
    localparam logic [FIVE_W-1:0] MID_DROP = FIVE_W'(FIVE_MOD - 2);

    logic [1:0]        falls;
    logic              zero_hit, nine_hit, override;
    logic              step_two, step_five;
    logic              half_q;
    logic [FIVE_W-1:0] five_cnt;
    order_e            order_q;

    // Decode the override pairs.
    assign zero_hit = zero_a & zero_b;
    assign nine_hit = nine_a & nine_b;
    assign override = zero_hit | nine_hit;

    fall_detect #(.W(2)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({strobe_five, strobe_two}),
        .fall  (falls)
    );

    // Take the cascade order only while the zero pair is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)        order_q <= ORDER_BCD;
        else if (zero_hit) order_q <= order_e'(order_sym);
    end

    // Route the steps by cascade order; the inner cascade acts in the same cycle.
    always_comb begin
        if (order_q == ORDER_BCD) begin
            step_two  = falls[0];
            step_five = falls[0] & half_q;
        end else begin
            step_two  = falls[1] & (five_cnt == MID_DROP);
            step_five = falls[1];
        end
        step_two  = step_two  & ~override;
        step_five = step_five & ~override;
    end

    half_stage u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_zero (zero_hit),
        .load_one  (nine_hit),
        .step      (step_two),
        .q         (half_q)
    );

    quint_stage #(.MOD(FIVE_MOD)) u_quint (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_zero (zero_hit),
        .load_top  (nine_hit),
        .step      (step_five),
        .cnt       (five_cnt)
    );

    // Pulse the carry when a step wraps the whole decade to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) decade_carry <= 1'b0;
        else        decade_carry <= step_five && (five_cnt == FIVE_TOP)
                                    && (order_q == ORDER_BCD || !half_q);
    end

    // Drive the outputs.
    assign q_a    = half_q;
    assign q_b    = five_cnt[0];
    assign q_c    = five_cnt[1];
    assign q_d    = five_cnt[2];
    assign bcd_ok = (order_q == ORDER_BCD);

    AST_NINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        nine_hit |=> (q_a && !q_b && !q_c && q_d)); // R9
    AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit && !nine_hit) |=> !(q_a || q_b || q_c || q_d)); // R8
    AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        decade_carry |=> !decade_carry); // R10
    AST_CARRY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        decade_carry |-> !(q_a || q_b || q_c || q_d)); // R10
    AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_hit |=> $stable(bcd_ok)); // R11
    AST_BCD_FIVE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd_ok && falls[1] && !falls[0] && !override) |=> $stable(five_cnt)); // R4
    AST_SYM_TWO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bcd_ok && falls[0] && !falls[1] && !override) |=> $stable(half_q)); // R6

endmodule

// File: tb/bisection_decade_test.sv
// Self-checking bench for bisection_decade: a vector table for BCD counting,
// followed by directed tests for overrides, order selection and reset.
module bisection_decade_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_two = 1'b0, strobe_five = 1'b0, order_sym = 1'b0;
    logic zero_a = 1'b0, zero_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
    logic q_a, q_b, q_c, q_d, decade_carry, bcd_ok;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    bisection_decade uut (
        .clk(clk), .rst_n(rst_n), .strobe_two(strobe_two), .strobe_five(strobe_five),
        .order_sym(order_sym), .zero_a(zero_a), .zero_b(zero_b),
        .nine_a(nine_a), .nine_b(nine_b), .q_a(q_a), .q_b(q_b), .q_c(q_c),
        .q_d(q_d), .decade_carry(decade_carry), .bcd_ok(bcd_ok)
    );

    // BCD table: {carry, qd, qc, qb, qa} after each strobe_two pulse.
    localparam logic [4:0] BCD_VEC [12] = '{
        5'b0_0001, 5'b0_0010, 5'b0_0011, 5'b0_0100, 5'b0_0101, 5'b0_0110,
        5'b0_0111, 5'b0_1000, 5'b0_1001, 5'b1_0000, 5'b0_0001, 5'b0_0010
    };

    function automatic logic [3:0] val();
        return {q_d, q_c, q_b, q_a};
    endfunction

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // One high-then-low pulse; sampled at the negedge after the step edge.
    task automatic pulse(input bit five);
        @(negedge clk);
        if (five) strobe_five = 1'b1; else strobe_two = 1'b1;
        @(negedge clk);
        if (five) strobe_five = 1'b0; else strobe_two = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset count/carry", {decade_carry, val()}, 5'b0_0000);
        check("R1 reset order", {4'b0, bcd_ok}, 5'd1);
        rst_n = 1'b1;

        // R3 / R10: BCD sequence through a wrap.
        for (int i = 0; i < 12; i++) begin
            pulse(1'b0);
            check($sformatf("R3 R10 bcd step %0d", i + 1), {decade_carry, val()}, BCD_VEC[i]);
            if (i == 9) begin
                @(negedge clk);
                check("R10 carry one cycle", {4'b0, decade_carry}, 5'd0);
            end
        end

        // R4: five strobe ignored in BCD order.
        pulse(1'b1);
        check("R4 five ignored", {1'b0, val()}, 5'd2);

        // R2: held high does not count; the fall does.
        @(negedge clk) strobe_two = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 level no step", {1'b0, val()}, 5'd2);
        strobe_two = 1'b0;
        @(negedge clk);
        check("R2 fall steps", {1'b0, val()}, 5'd3);

        // R8: half the zero pair does nothing; full pair clears and holds.
        zero_a = 1'b1;
        pulse(1'b0);
        check("R8 single zero input", {1'b0, val()}, 5'd4);
        zero_b = 1'b1;
        @(negedge clk);
        check("R8 clear", {1'b0, val()}, 5'd0);
        pulse(1'b0);
        check("R8 hold while clearing", {decade_carry, val()}, 5'd0);
        zero_a = 1'b0; zero_b = 1'b0;

        // R9: half the nine pair does nothing; full pair loads nine; wins over zero.
        nine_b = 1'b1;
        pulse(1'b0);
        check("R9 single nine input", {1'b0, val()}, 5'd1);
        nine_a = 1'b1;
        @(negedge clk);
        check("R9 load nine", {decade_carry, val()}, 5'b0_1001);
        zero_a = 1'b1; zero_b = 1'b1;
        @(negedge clk);
        check("R9 priority over zero", {decade_carry, val()}, 5'b0_1001);
        zero_a = 1'b0; zero_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0;
        pulse(1'b0);
        check("R10 carry from nine", {decade_carry, val()}, 5'b1_0000);

        // R11: order change outside a clear has no effect.
        order_sym = 1'b1;
        pulse(1'b0);
        check("R11 order ignored outside clear", {bcd_ok, val()}, 5'b1_0001);
        zero_a = 1'b1; zero_b = 1'b1;
        @(negedge clk);
        zero_a = 1'b0; zero_b = 1'b0; order_sym = 1'b0;
        @(negedge clk);
        check("R7 R11 symmetric taken in clear", {bcd_ok, val()}, 5'b0_0000);

        // R5 / R10: symmetric sequence over two decades, model from the requirement.
        for (int n = 1; n <= 20; n++) begin
            logic [2:0] c;
            logic       a;
            c = 3'(n % 5);
            a = ((n % 10) >= 4) && ((n % 10) <= 8);
            pulse(1'b1);
            check($sformatf("R5 R10 sym step %0d", n), {decade_carry, val()},
                  {(n % 10) == 0, c, a});
        end

        // R6: two strobe ignored in symmetric order (value 0 after 20 steps).
        pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b1);
        check("R5 sym toggle at 4", {1'b0, val()}, 5'b0_1001);
        pulse(1'b0);
        check("R6 two ignored", {1'b0, val()}, 5'b0_1001);
        check("R7 flag in symmetric", {4'b0, bcd_ok}, 5'd0);

        // R1: reset in mid-count.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-count", {decade_carry, val()}, 5'd0);
        check("R1 reset order", {4'b0, bcd_ok}, 5'd1);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule